// File: doc/BRIEF.md
# Alignment Check and Split Detector

This block sits next to a load/store pipeline and looks at every memory access it is offered: the byte address, the access size, and whether it is a load or a store. It combines that access with the current privilege level, the execution mode and two enable bits. One enable bit comes from a control register and the other from a flags register. From these it decides whether the access must raise an alignment-check fault. The fault is reported as a one-cycle pulse. Delivering the exception is left to the surrounding logic.

Independently of the fault, the block reports whether the access straddles a 64-byte cache line or a 4 KiB page. It also keeps two saturating counters, one for split loads and one for split stores, so performance tooling can locate costly line-crossing traffic. An access that is misaligned but stays inside one line is not counted or flagged, because it carries no extra cost. The block does not perform the memory access itself.

Top module: `acc_align_split`

## Requirements
- R1: The size input is a log2 code (0=1, 1=2, 2=4, 3=8, 4=16, 5=32, 6=64 bytes; code 7 behaves as 64 bytes). An access is misaligned when its address modulo its size is nonzero. With every gate open, a misaligned access faults and an aligned one never does.
- R2: A fault needs both enable inputs, the control mask bit and the flags check bit, to be 1. If either is 0, no fault is raised.
- R3: Privilege levels 0, 1 and 2 never raise the fault. Only level 3 can.
- R4: The mode input is encoded 00 real, 01 protected, 10 virtual-8086 and 11 other. Only codes 01 and 10 allow a fault.
- R5: The line-split flag is set when the first and last byte of the access lie in different 64-byte lines. A misaligned access inside one line leaves the flag at 0.
- R6: The page-split flag is set when the first and last byte lie in different 4 KiB pages. Whenever it is 1, the line-split flag is also 1.
- R7: The fault and split outputs are registered. They appear in the cycle after the access is presented and last one cycle per access. They are 0 in any cycle that follows one with the valid input low.
- R8: Each access with a line split adds one to the store counter if it is a store, or to the load counter if it is a load. Other accesses leave both counters unchanged.
- R9: A counter that has reached its maximum value stays there on further split accesses (default width 32 bits).
- R10: The clear input sets both counters to 0 at the next edge and takes priority over an increment in the same cycle. The active-low synchronous reset zeroes all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W (32) | Byte address of the first byte |
| acc_size_lg | input | 3 | Access size as log2 of bytes |
| acc_is_store | input | 1 | 1 for store, 0 for load |
| ctl_align_mask | input | 1 | Alignment mask bit from the control register |
| flg_align_chk | input | 1 | Alignment check bit from the flags register |
| cur_priv | input | 2 | Current privilege level |
| exec_mode | input | 2 | Execution mode code |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| fault_pulse | output | 1 | Alignment-check fault for the previous cycle's access |
| split_line | output | 1 | Previous access crossed a line boundary |
| split_page | output | 1 | Previous access crossed a page boundary |
| split_ld_cnt | output | CNT_W (32) | Saturating count of split loads |
| split_st_cnt | output | CNT_W (32) | Saturating count of split stores |

## Verification
The embedded properties check the following on every cycle:
- No fault follows a cycle in which an enable bit is low, the privilege level is not 3, the mode disallows checking, or no access was offered.
- A page split never appears without a line split.
- Counters only hold, step by one, saturate or clear.

What they cannot show is that the arithmetic is right. Whether a given address and size really is misaligned or really crosses a line or page, and whether the right counter moved by the right amount, only comes out of the bench's sweep. That sweep runs across every size code and the addresses around a page boundary, and compares against the modulo rules. The bench also walks every combination of the gating inputs and runs counter runs that reach saturation and clear with a competing increment.

// File: rtl/acc_align_pkg.sv
// Package: shared types and helpers for the alignment check and split
// detector. Assumes a two-bit mode code and two-bit privilege level.
package acc_align_pkg;

    // Execution mode codes as seen at the block's mode input.
    typedef enum logic [1:0] {
        MODE_REAL  = 2'b00,
        MODE_PROT  = 2'b01,
        MODE_V86   = 2'b10,
        MODE_OTHER = 2'b11
    } exec_mode_e;

    // Privilege level at which alignment checking may take effect.
    localparam logic [1:0] PRIV_USER = 2'd3;

    // True for the modes in which alignment checking is defined.
    function automatic logic mode_allows_check(input exec_mode_e m);
        return (m == MODE_PROT) || (m == MODE_V86);
    endfunction

endpackage

// File: rtl/acc_split_detect.sv
// Split and misalignment detector (combinational).
// Computes the address of the last byte of an access and compares the line
// and page numbers of the first and last bytes. A carry out of the top of
// the address space also counts as a split. Sizes are powers of two; size
// codes above MAX_SIZE_LG are clamped to it. Assumes MAX_SIZE_LG <= LINE_LG.
module acc_split_detect #(
    parameter int ADDR_W      = 32,
    parameter int SIZE_LG_W   = 3,
    parameter int MAX_SIZE_LG = 6,
    parameter int LINE_LG     = 6,
    parameter int PAGE_LG     = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [SIZE_LG_W-1:0] size_lg,
    output logic                 misaligned,
    output logic                 line_split,
    output logic                 page_split
);
    localparam int AW1 = ADDR_W + 1;

    logic [SIZE_LG_W-1:0] eff_lg;
    logic [AW1-1:0]       size_m1;
    logic [AW1-1:0]       last_addr;
    logic [AW1-1:0]       first_addr;

    // Clamp the size code and form (size - 1) as an address-wide mask.
    always_comb begin
        eff_lg  = (size_lg > SIZE_LG_W'(MAX_SIZE_LG)) ? SIZE_LG_W'(MAX_SIZE_LG) : size_lg;
        size_m1 = (AW1'(1) << eff_lg) - AW1'(1);
    end

    // Locate the last byte, with one extra bit to catch wrap-around.
    always_comb begin
        first_addr = {1'b0, addr};
        last_addr  = first_addr + size_m1;
    end

    // Misaligned when any address bit below the size is set; split when the
    // line or page index of the last byte differs from that of the first.
    always_comb begin
        misaligned = |(addr & size_m1[ADDR_W-1:0]);
        line_split = (last_addr[AW1-1:LINE_LG] != first_addr[AW1-1:LINE_LG]);
        page_split = (last_addr[AW1-1:PAGE_LG] != first_addr[AW1-1:PAGE_LG]);
    end

endmodule

// File: rtl/acc_fault_gate.sv
// Alignment fault gate (combinational).
// Raises a fault request only for a valid, misaligned access when both
// enable bits are set, the privilege level is the user level and the mode
// is one in which checking is defined. Assumes inputs are stable in-cycle.
module acc_fault_gate
    import acc_align_pkg::*;
(
    input  logic       valid,
    input  logic       misaligned,
    input  logic       mask_en,
    input  logic       chk_en,
    input  logic [1:0] priv,
    input  logic [1:0] mode,
    output logic       fault_req
);
    logic enables_ok;
    logic priv_ok;
    logic mode_ok;

    // Evaluate each gating term separately, then combine with the access.
    always_comb begin
        enables_ok = mask_en & chk_en;
        priv_ok    = (priv == PRIV_USER);
        mode_ok    = mode_allows_check(exec_mode_e'(mode));
        fault_req  = valid & misaligned & enables_ok & priv_ok & mode_ok;
    end

endmodule

// File: rtl/acc_sat_counter.sv
// Saturating event counter with synchronous clear.
// Adds one per cycle with inc set, holds at the all-ones value, and returns
// to zero on clr (which wins over inc) or on the active-low reset.
module acc_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count register: reset/clear first, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R9
    hold_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/acc_align_split.sv
// Alignment check and split detector, top level.
// Registers the fault, line-split and page-split results of each access
// for one cycle and keeps separate saturating counts of split loads and
// split stores. Assumes at most one access per cycle.
module acc_align_split
    import acc_align_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 32,
    parameter int LINE_LG     = 6,
    parameter int PAGE_LG     = 12,
    parameter int MAX_SIZE_LG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size_lg,
    input  logic              acc_is_store,
    input  logic              ctl_align_mask,
    input  logic              flg_align_chk,
    input  logic [1:0]        cur_priv,
    input  logic [1:0]        exec_mode,
    input  logic              cnt_clr,
    output logic              fault_pulse,
    output logic              split_line,
    output logic              split_page,
    output logic [CNT_W-1:0]  split_ld_cnt,
    output logic [CNT_W-1:0]  split_st_cnt
);
    localparam int NUM_CNT = 2;   // index 0: loads, index 1: stores

    logic             misal_d;
    logic             line_d;
    logic             page_d;
    logic             fault_d;
    logic [CNT_W-1:0] cnt_q [NUM_CNT];

    acc_split_detect #(
        .ADDR_W      (ADDR_W),
        .SIZE_LG_W   (3),
        .MAX_SIZE_LG (MAX_SIZE_LG),
        .LINE_LG     (LINE_LG),
        .PAGE_LG     (PAGE_LG)
    ) u_detect (
        .addr       (acc_addr),
        .size_lg    (acc_size_lg),
        .misaligned (misal_d),
        .line_split (line_d),
        .page_split (page_d)
    );

    acc_fault_gate u_gate (
        .valid      (acc_valid),
        .misaligned (misal_d),
        .mask_en    (ctl_align_mask),
        .chk_en     (flg_align_chk),
        .priv       (cur_priv),
        .mode       (exec_mode),
        .fault_req  (fault_d)
    );

    // Output stage: one-cycle result flags for the accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_pulse <= 1'b0;
            split_line  <= 1'b0;
            split_page  <= 1'b0;
        end else begin
            fault_pulse <= fault_d;
            split_line  <= acc_valid & line_d;
            split_page  <= acc_valid & page_d;
        end
    end

    // One saturating counter per access direction.
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        logic dir_match;
        assign dir_match = (acc_is_store == (gi == 1));
        acc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (acc_valid & line_d & dir_match),
            .cnt   (cnt_q[gi])
        );
    end

    assign split_ld_cnt = cnt_q[0];
    assign split_st_cnt = cnt_q[1];

    // R2
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_align_mask || !flg_align_chk) |=> !fault_pulse);

    // R3
    priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv != PRIV_USER) |=> !fault_pulse);

    // R4
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_mode == MODE_REAL || exec_mode == MODE_OTHER) |=> !fault_pulse);

    // R6
    page_implies_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_page |-> split_line);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!fault_pulse && !split_line && !split_page));

endmodule

// File: tb/acc_align_split_tb.sv
`timescale 1ns/1ps
module acc_align_split_tb;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_size_lg = '0;
    logic        acc_is_store = 1'b0;
    logic        ctl_align_mask = 1'b0;
    logic        flg_align_chk = 1'b0;
    logic [1:0]  cur_priv = 2'd0;
    logic [1:0]  exec_mode = 2'd0;
    logic        cnt_clr = 1'b0;
    logic        fault_pulse, split_line, split_page;
    logic [CW-1:0] split_ld_cnt, split_st_cnt;

    int checks = 0;
    int errors = 0;
    int ld_exp = 0;
    int st_exp = 0;

    always #2.5 clk = ~clk;

    acc_align_split #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size_lg(acc_size_lg), .acc_is_store(acc_is_store),
        .ctl_align_mask(ctl_align_mask), .flg_align_chk(flg_align_chk),
        .cur_priv(cur_priv), .exec_mode(exec_mode), .cnt_clr(cnt_clr),
        .fault_pulse(fault_pulse), .split_line(split_line), .split_page(split_page),
        .split_ld_cnt(split_ld_cnt), .split_st_cnt(split_st_cnt)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Present one access at a falling edge, then check at the next falling edge.
    task automatic access(input logic [31:0] a, input logic [2:0] code,
                          input logic st, input logic clr);
        longint size, off_l, off_p;
        logic misal, lsplit, psplit, gate, exp_fault;
        acc_valid = 1'b1; acc_addr = a; acc_size_lg = code;
        acc_is_store = st; cnt_clr = clr;
        size   = (code > 3'd6) ? 64 : (longint'(1) << code);
        off_l  = longint'(a) % 64;
        off_p  = longint'(a) % 4096;
        misal  = (longint'(a) % size) != 0;
        lsplit = (off_l + size - 1) >= 64;
        psplit = (off_p + size - 1) >= 4096;
        gate   = ctl_align_mask && flg_align_chk && (cur_priv == 2'd3) &&
                 (exec_mode == 2'd1 || exec_mode == 2'd2);
        exp_fault = gate && misal;
        if (clr) begin
            ld_exp = 0; st_exp = 0;
        end else if (lsplit) begin
            if (st) st_exp = (st_exp == CMAX) ? CMAX : st_exp + 1;
            else    ld_exp = (ld_exp == CMAX) ? CMAX : ld_exp + 1;
        end
        @(negedge clk);
        cnt_clr = 1'b0;
        check("R1 fault on misalignment", fault_pulse, exp_fault);
        check("R5 line split", split_line, lsplit);
        check("R6 page split", split_page, psplit);
        check("R8 split load count", split_ld_cnt, ld_exp);
        check("R8 split store count", split_st_cnt, st_exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 reset fault", fault_pulse, 0);
        check("R10 reset line", split_line, 0);
        check("R10 reset page", split_page, 0);
        check("R10 reset ld cnt", split_ld_cnt, 0);
        check("R10 reset st cnt", split_st_cnt, 0);

        ctl_align_mask = 1; flg_align_chk = 1; cur_priv = 3; exec_mode = 1;

        // R8 directed counting: split load, split store, unsplit misaligned
        access(32'h0000_003E, 3'd2, 1'b0, 1'b0);   // 4B at 0x3E: split load
        access(32'h0000_007C, 3'd3, 1'b1, 1'b0);   // 8B at 0x7C: split store
        access(32'h0000_0081, 3'd1, 1'b1, 1'b0);   // R5 misaligned inside line
        access(32'h0000_0FFF, 3'd1, 1'b0, 1'b0);   // R6 page split load

        // R7 result lasts one cycle; idle cycle is quiet and counters hold
        acc_valid = 1'b0;
        @(negedge clk);
        check("R7 idle fault", fault_pulse, 0);
        check("R7 idle line", split_line, 0);
        check("R7 idle page", split_page, 0);
        check("R8 idle ld cnt", split_ld_cnt, ld_exp);
        check("R8 idle st cnt", split_st_cnt, st_exp);

        // R10 clear wins over a concurrent split increment
        access(32'h0000_003F, 3'd1, 1'b0, 1'b1);
        check("R10 clear priority ld", split_ld_cnt, 0);

        // R1 R5 R6 R9 sweep: every size code, both directions, around a page edge
        for (int d = 0; d < 2; d++)
            for (int c = 0; c < 8; c++)
                for (int a = 32'h0FC0; a < 32'h1040; a++)
                    access(32'(a), 3'(c), d[0], 1'b0);
        // R9 both counters pinned at maximum after the sweep
        check("R9 ld saturated", split_ld_cnt, CMAX);
        check("R9 st saturated", split_st_cnt, CMAX);

        // R5 R6 wrap at top of address space counts as split
        access(32'hFFFF_FFF8, 3'd4, 1'b0, 1'b1);

        // R2 R3 R4 gating sweep with a misaligned, unsplit 2-byte access
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 2; f++)
                for (int p = 0; p < 4; p++)
                    for (int md = 0; md < 4; md++) begin
                        ctl_align_mask = m[0]; flg_align_chk = f[0];
                        cur_priv = 2'(p); exec_mode = 2'(md);
                        access(32'h0000_2101, 3'd1, 1'b1, 1'b0);
                        check("R2 R3 R4 gated fault", fault_pulse,
                              (m == 1 && f == 1 && p == 3 && (md == 1 || md == 2)) ? 1 : 0);
                    end

        acc_valid = 1'b0;
        @(negedge clk);
        summary();
        $finish;
    end
endmodule